// File: doc/BRIEF.md
# Watchdog with Safe Frequency Fallback

This block guards the frequency-select code of a programmable clock generator. Software arms it by setting one or both alarm enables in a control register. While armed, it counts elapsed time units, and each pulse on `kick` restarts the count. A unit is either one pulse of the prescaled `tick` input (short base) or `LONG_DIV` such pulses (long base). The timeout is the 3-bit count field times the selected unit.

When the timeout is reached, the block sets the sticky status of every alarm that is enabled. If the hard alarm is enabled, it also captures a safe 5-bit frequency code and drives that code on `freq_code` in place of the live code. The code stays captured until reset. The safe code comes from one of two places, chosen by a source bit: the strap code latched at power-up, or a code programmed in a register.

Registers are written with a plain strobe and address. Their contents are always visible on the read buses, and the status bits appear on their own output pins. `kick` and `tick` are single-cycle pulses with no flow control: a pulse is taken in the cycle it is high.

Top module: `wdog_safe_freq`

## Requirements
- R1: After reset, `ctrl_rd` is 0x38 (both enables 0, short base, count 7, M/N override 0), `safe_rd` is 0, both alarm outputs are 0, and `freq_code` equals `live_code`.
- R2: A write with `cfg_addr`=0 loads `ctrl_rd` from `cfg_wdata[6:0]`. The layout is: bit0 soft enable, bit1 hard enable, bit2 long-base select, bits5:3 count, bit6 M/N override. A write with `cfg_addr`=1 loads `safe_rd` from `cfg_wdata[5:0]`: bits4:0 programmed safe code, bit5 source select. No write can raise an alarm output.
- R3: With the short base and count C≥1, an alarm output rises at the clock edge that samples the C-th `tick` since the last restart. The restart happens on any control write, a kick, or an expiry.
- R4: With the long base, expiry needs C×LONG_DIV ticks (LONG_DIV=4).
- R5: A `kick` pulse discards all progress: expiry needs a full timeout of ticks after the kick, and no alarm rises in the cycle after a kick.
- R6: While both enables are 0, no number of ticks raises an alarm.
- R7: On expiry with only the soft enable set, `soft_alarm` goes to 1, `hard_alarm` stays 0, and `freq_code` keeps following `live_code`.
- R8: On expiry with the hard enable set, `hard_alarm` goes to 1 and `freq_code` switches to the safe code in the same edge. The code then holds, whatever `live_code` does, until reset, even after the hard status is cleared.
- R9: The safe code captured at the first hard expiry is `strap_code` when source=0 and the programmed code when source=1.
- R10: Each status bit stays 1 until a control write puts its enable to 0. A write that keeps the enable at 1 leaves the status set.
- R11: `mn_override` follows control bit 6.
- R12: A count of 0 expires at the first unit boundary, the same as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = control register, 1 = safe-code register |
| cfg_wdata | input | 7 | Write data |
| ctrl_rd | output | 7 | Control register contents |
| safe_rd | output | 6 | Safe-code register contents |
| kick | input | 1 | Restart pulse |
| tick | input | 1 | Prescaled short time-base pulse |
| strap_code | input | 5 | Code latched from straps at power-up |
| live_code | input | 5 | Normal frequency-select code |
| freq_code | output | 5 | Effective frequency-select code |
| mn_override | output | 1 | Divider override enable |
| soft_alarm | output | 1 | Soft alarm status |
| hard_alarm | output | 1 | Hard alarm status |

## Verification
The hardest state to reach is a forced output whose hard status has already been cleared. Only that state shows that the captured code is held apart from the status bit. The stimulus gets there by letting a hard expiry happen, then writing the hard enable to 0, changing `live_code` and changing the source bit, and checking that `freq_code` still holds the first captured code. The timer is swept over both bases and all eight counts, with a check after every tick, so the exact edge of expiry is pinned for each setting.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W    = 3;
  localparam int CODE_W   = 5;
  localparam int CTRL_W   = 7;
  localparam int SAFE_W   = CODE_W + 1;
  localparam int B_SOFT   = 0;
  localparam int B_HARD   = 1;
  localparam int B_BASE   = 2;
  localparam int B_CNT    = 3;
  localparam int B_MN     = 6;
  localparam int B_SRC    = CODE_W;
  localparam logic [CNT_W-1:0] CNT_RST = '1;

  typedef struct packed {
    logic             mn_en;
    logic [CNT_W-1:0] count;
    logic             long_base;
    logic             hard_en;
    logic             soft_en;
  } ctrl_t;

  typedef struct packed {
    logic              src_prog;
    logic [CODE_W-1:0] code;
  } safe_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              expire,
  output ctrl_t             ctrl,
  output safe_t             safe,
  output logic              ctrl_wr,
  output logic              soft_st,
  output logic              hard_st
);
  ctrl_t ctrl_q;
  safe_t safe_q;
  ctrl_t ctrl_new;

  assign ctrl_new = ctrl_t'(cfg_wdata);
  assign ctrl_wr  = cfg_wr && !cfg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '{mn_en: 1'b0, count: CNT_RST, long_base: 1'b0,
                  hard_en: 1'b0, soft_en: 1'b0};
      safe_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr) safe_q <= safe_t'(cfg_wdata[SAFE_W-1:0]);
      else          ctrl_q <= ctrl_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_st <= 1'b0;
      hard_st <= 1'b0;
    end else begin
      if (ctrl_wr && !ctrl_new.soft_en)      soft_st <= 1'b0;
      else if (expire && ctrl_q.soft_en)     soft_st <= 1'b1;
      if (ctrl_wr && !ctrl_new.hard_en)      hard_st <= 1'b0;
      else if (expire && ctrl_q.hard_en)     hard_st <= 1'b1;
    end
  end

  assign ctrl = ctrl_q;
  assign safe = safe_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int LONG_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             restart,
  input  logic             tick,
  input  logic             long_base,
  input  logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int SUB_W = (LONG_DIV > 1) ? $clog2(LONG_DIV) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(LONG_DIV - 1);

  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] units_q;
  logic             unit_done;
  logic [CNT_W:0]   units_next;
  logic             hold;

  assign hold       = restart || !armed;
  assign unit_done  = tick && (!long_base || sub_q == SUB_LAST);
  assign units_next = {1'b0, units_q} + 1'b1;
  assign expire     = !hold && unit_done && (units_next >= {1'b0, count});

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      sub_q   <= '0;
      units_q <= '0;
    end else if (tick) begin
      if (unit_done) sub_q <= '0;
      else           sub_q <= sub_q + 1'b1;
      if (expire)         units_q <= '0;
      else if (unit_done) units_q <= units_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/wdog_freq_sel.sv
module wdog_freq_sel
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  safe_t             safe,
  input  logic [CODE_W-1:0] strap_code,
  input  logic [CODE_W-1:0] live_code,
  output logic [CODE_W-1:0] freq_code
);
  logic              forced_q;
  logic [CODE_W-1:0] held_q;
  logic [CODE_W-1:0] pick;

  assign pick = safe.src_prog ? safe.code : strap_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      forced_q <= 1'b0;
      held_q   <= '0;
    end else if (capture && !forced_q) begin
      forced_q <= 1'b1;
      held_q   <= pick;
    end
  end

  assign freq_code = forced_q ? held_q : live_code;
endmodule

// File: rtl/wdog_safe_freq.sv
module wdog_safe_freq
  import wdog_pkg::*;
#(
  parameter int LONG_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [SAFE_W-1:0] safe_rd,
  input  logic              kick,
  input  logic              tick,
  input  logic [CODE_W-1:0] strap_code,
  input  logic [CODE_W-1:0] live_code,
  output logic [CODE_W-1:0] freq_code,
  output logic              mn_override,
  output logic              soft_alarm,
  output logic              hard_alarm
);
  ctrl_t ctrl;
  safe_t safe;
  logic  ctrl_wr;
  logic  expire;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .expire(expire), .ctrl(ctrl), .safe(safe),
    .ctrl_wr(ctrl_wr), .soft_st(soft_alarm), .hard_st(hard_alarm)
  );

  wdog_timer #(.LONG_DIV(LONG_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .armed(ctrl.soft_en || ctrl.hard_en),
    .restart(kick || ctrl_wr), .tick(tick), .long_base(ctrl.long_base),
    .count(ctrl.count), .expire(expire)
  );

  wdog_freq_sel u_sel (
    .clk(clk), .rst_n(rst_n), .capture(expire && ctrl.hard_en),
    .safe(safe), .strap_code(strap_code), .live_code(live_code),
    .freq_code(freq_code)
  );

  assign ctrl_rd     = ctrl;
  assign safe_rd     = safe;
  assign mn_override = ctrl.mn_en;
endmodule

// File: rtl/wdog_safe_freq_chk.sv
module wdog_safe_freq_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              kick,
  input logic              tick,
  input logic [CTRL_W-1:0] ctrl_rd,
  input logic [CODE_W-1:0] freq_code,
  input logic              soft_alarm,
  input logic              hard_alarm
);
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_alarm) |-> $past(tick)); // R3
  AST_KICK_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !$rose(soft_alarm) && !$rose(hard_alarm)); // R5
  AST_SOFT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_alarm) |-> $past(ctrl_rd[B_SOFT])); // R6
  AST_HARD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hard_alarm |=> $stable(freq_code)); // R8
  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_alarm) |-> $past(cfg_wr)); // R10
endmodule

bind wdog_safe_freq wdog_safe_freq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .kick(kick), .tick(tick),
  .ctrl_rd(ctrl_rd), .freq_code(freq_code), .soft_alarm(soft_alarm),
  .hard_alarm(hard_alarm)
);

// File: tb/sim_wdog_safe_freq.sv
module sim_wdog_safe_freq;
  localparam int LD = 4;
  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [6:0] ctrl_rd;
  logic [5:0] safe_rd;
  logic kick = 1'b0, tick = 1'b0;
  logic [4:0] strap_code = 5'h0A, live_code = 5'h04, freq_code;
  logic mn_override, soft_alarm, hard_alarm;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_safe_freq #(.LONG_DIV(LD)) u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic a, logic [6:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  function automatic logic [6:0] ctl(bit s, bit h, bit b, int c, bit m);
    return {m, 3'(c), b, h, s};
  endfunction

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    do_reset();
    chk("R1 ctrl", 8'(ctrl_rd), 8'h38);
    chk("R1 safe", 8'(safe_rd), 8'h00);
    chk("R1 alarms", {6'b0, hard_alarm, soft_alarm}, 8'h00);
    chk("R1 freq", 8'(freq_code), 8'h04);

    // R2 / R11 layout and readback
    wr(1'b0, ctl(0, 0, 1, 5, 1));
    chk("R2 ctrl", 8'(ctrl_rd), 8'(ctl(0, 0, 1, 5, 1)));
    chk("R11 mn on", 8'(mn_override), 8'h01);
    wr(1'b1, 7'h33);
    chk("R2 safe", 8'(safe_rd), 8'h33);
    wr(1'b0, ctl(0, 0, 0, 7, 0));
    chk("R11 mn off", 8'(mn_override), 8'h00);
    chk("R2 no alarm", {6'b0, hard_alarm, soft_alarm}, 8'h00);

    // R3 R4 R12 sweep of base and count with soft alarm
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 8; c++) begin
        int need;
        need = ((c == 0) ? 1 : c) * ((b == 1) ? LD : 1);
        do_reset();
        wr(1'b0, ctl(1, 0, b[0], c, 0));
        for (int t = 1; t <= need; t++) begin
          pulse_tick();
          chk((c == 0) ? "R12 sweep" : (b == 1 ? "R4 sweep" : "R3 sweep"),
              8'(soft_alarm), 8'(t >= need));
        end
        chk("R7 no hard", 8'(hard_alarm), 8'h00);
        chk("R7 freq live", 8'(freq_code), 8'h04);
      end
    end

    // R10 sticky status
    wr(1'b0, ctl(1, 0, 0, 7, 0));
    chk("R10 kept", 8'(soft_alarm), 8'h01);
    wr(1'b0, ctl(0, 0, 0, 7, 0));
    chk("R10 cleared", 8'(soft_alarm), 8'h00);

    // R6 idle
    for (int t = 0; t < 40; t++) pulse_tick();
    chk("R6 idle", {6'b0, hard_alarm, soft_alarm}, 8'h00);

    // R5 kick
    do_reset();
    wr(1'b0, ctl(1, 0, 0, 3, 0));
    pulse_tick(); pulse_tick();
    pulse_kick();
    chk("R5 after kick", 8'(soft_alarm), 8'h00);
    pulse_tick(); pulse_tick();
    chk("R5 two after", 8'(soft_alarm), 8'h00);
    pulse_tick();
    chk("R5 three after", 8'(soft_alarm), 8'h01);

    // R8 R9 hard with programmed code
    do_reset();
    wr(1'b1, 7'h33);
    wr(1'b0, ctl(0, 1, 0, 2, 0));
    pulse_tick();
    chk("R8 before", 8'(freq_code), 8'h04);
    pulse_tick();
    chk("R8 hard", 8'(hard_alarm), 8'h01);
    chk("R8 soft off", 8'(soft_alarm), 8'h00);
    chk("R9 prog code", 8'(freq_code), 8'h13);
    live_code = 5'h1F;
    wr(1'b1, 7'h05);
    pulse_tick(); pulse_tick();
    chk("R8 held live", 8'(freq_code), 8'h13);
    wr(1'b0, ctl(0, 0, 0, 2, 0));
    chk("R10 hard clr", 8'(hard_alarm), 8'h00);
    chk("R8 held clr", 8'(freq_code), 8'h13);
    do_reset();
    chk("R8 reset", 8'(freq_code), 8'h1F);

    // R9 strap source, both alarms
    wr(1'b1, 7'h11);
    wr(1'b0, ctl(1, 1, 0, 1, 0));
    pulse_tick();
    chk("R9 strap", 8'(freq_code), 8'h0A);
    chk("R8 both", {6'b0, hard_alarm, soft_alarm}, 8'h03);

    finish_run();
  end
endmodule